// File: doc/BRIEF.md
# Addressing-Mode Branch Execution Unit

This execute-stage unit serves a 32-bit register machine whose address space can be narrowed to 24 bits or widened to 31 bits. It carries one bit of state, the addressing mode, and it executes the instructions that read or change that bit. These are the mode-setting branches, the branch-and-link family, the insert-mask instruction and the load-address computation. Register operands arrive already read. The unit returns a write-back word with its enable, a branch-taken flag with its target, and the current mode.

The outputs are combinational in the cycle where `instr_valid` is high. A mode change takes effect at the next rising clock edge. From then on every mode-dependent instruction uses the new mode. Bit numbering in this document follows vector indices: bit 31 is the most significant bit, which is the mode bit in register images.

Top module: `amb_exec_unit`

## Requirements
- R1: After reset `amode` is 0, which selects 24-bit mode.
- R2: Opcode 0x0B (mode-save branch) writes `{amode, r1_low[30:0]}` to the register.
- R3: For opcodes 0x0B and 0x0C with `r2_num` nonzero, `br_taken` is 1 and `br_target` is `{0, r2_val[30:0]}`. After the next clock edge `amode` equals `r2_val[31]`.
- R4: For opcodes 0x0B and 0x0C with `r2_num` zero, `br_taken` is 0, `br_target` is 0 and `amode` does not change.
- R5: Opcode 0x0C (mode-save-and-link branch) writes `{amode, next_ia[30:0]}`.
- R6: Opcode 0x41 (load address) writes the effective address. The effective address is the 32-bit sum of base, index and the zero-extended 12-bit displacement. A base or index register number of 0 adds zero. In 31-bit mode bit 31 of the sum is cleared. In 24-bit mode bits 31:24 are cleared.
- R7: Opcode 0xB2 (insert mask) writes `{2'b00, cc, prog_mask, r1_low[23:0]}`.
- R8: Only opcodes 0x0B and 0x0C change `amode`. Every other opcode, and an idle cycle, leaves it unchanged.
- R9: Opcodes 0x05 (register link) and 0x45 (indexed link) write `{1, next_ia[30:0]}` in 31-bit mode. In 24-bit mode they write `{ilc, cc, prog_mask, next_ia[23:0]}`, where ilc is 2'b01 for 0x05 and 2'b10 for 0x45.
- R10: Opcodes 0x0D (register save) and 0x4D (indexed save) write `{1, next_ia[30:0]}` in 31-bit mode and `{8'h00, next_ia[23:0]}` in 24-bit mode.
- R11: Opcodes 0x05 and 0x0D branch only when `r2_num` is nonzero. Their target is `r2_val` masked like an R6 address in the current mode. Opcodes 0x45 and 0x4D always branch to the R6 effective address.
- R12: When `instr_valid` is 0, or the opcode is not listed above, `wb_en`, `wb_data`, `br_taken` and `br_target` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | An instruction is presented this cycle |
| opcode | input | 8 | Operation code |
| r2_num | input | 4 | Register number of the second operand |
| r1_low | input | 31 | Bits 30:0 of the first-operand register |
| r2_val | input | 32 | Second-operand register value |
| base_num | input | 4 | Base register number |
| base_val | input | 32 | Base register value |
| index_num | input | 4 | Index register number |
| index_val | input | 32 | Index register value |
| disp | input | 12 | Address displacement |
| next_ia | input | 31 | Address of the following instruction |
| cc | input | 2 | Condition code |
| prog_mask | input | 4 | Program mask |
| wb_en | output | 1 | Write `wb_data` to the first-operand register |
| wb_data | output | 32 | Write-back value |
| br_taken | output | 1 | Branch taken |
| br_target | output | 32 | Branch target address |
| amode | output | 1 | Current mode: 1 is 31-bit, 0 is 24-bit |

## Verification
The only internal state is the mode bit, and `amode` exposes it directly. A wrong mode would be visible one cycle after the mode branch that set it. It would also appear at once in the next load-address, link or register-branch result, because their high byte and bit 31 change shape with the mode. A wrong decode or a wrong mask shows in the same cycle on `wb_data` or `br_target`.

// File: rtl/amb_pkg.sv
package amb_pkg;
   localparam int CC_W  = 2;
   localparam int PM_W  = 4;
   localparam int ILC_W = 2;

   typedef enum logic [7:0] {
      OP_BALR  = 8'h05,
      OP_MSB   = 8'h0B,
      OP_MSBL  = 8'h0C,
      OP_BASR  = 8'h0D,
      OP_LA    = 8'h41,
      OP_BAL   = 8'h45,
      OP_BAS   = 8'h4D,
      OP_IMASK = 8'hB2
   } amb_op_e;

   localparam logic [ILC_W-1:0] ILC_RR = 2'b01;
   localparam logic [ILC_W-1:0] ILC_RX = 2'b10;
endpackage

// File: rtl/amb_ea_gen.sv
module amb_ea_gen #(
   parameter int XLEN     = 32,
   parameter int NARROW_W = 24,
   parameter int DISP_W   = 12,
   parameter int RIDX_W   = 4,
   parameter bit ADD3_CSA = 1'b1
) (
   input  logic              wide_mode,
   input  logic [RIDX_W-1:0] base_num,
   input  logic [XLEN-1:0]   base_val,
   input  logic [RIDX_W-1:0] index_num,
   input  logic [XLEN-1:0]   index_val,
   input  logic [DISP_W-1:0] disp,
   output logic [XLEN-1:0]   ea
);
   localparam logic [XLEN-1:0] NARROW_MASK = {{(XLEN-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
   localparam logic [XLEN-1:0] WIDE_MASK   = {1'b0, {(XLEN-1){1'b1}}};
   localparam int NOPND = 2;

   logic [NOPND-1:0][RIDX_W-1:0] opnd_num;
   logic [NOPND-1:0][XLEN-1:0]   opnd_raw;
   logic [NOPND-1:0][XLEN-1:0]   opnd_gated;
   logic [XLEN-1:0]              disp_ext;
   logic [XLEN-1:0]              sum;

   assign opnd_num = {index_num, base_num};
   assign opnd_raw = {index_val, base_val};
   assign disp_ext = {{(XLEN-DISP_W){1'b0}}, disp};

   // register number zero stands for a zero operand
   for (genvar i = 0; i < NOPND; i++) begin : g_opnd
      assign opnd_gated[i] = (opnd_num[i] == '0) ? '0 : opnd_raw[i];
   end

   if (ADD3_CSA) begin : g_csa
      logic [XLEN-1:0] s_part;
      logic [XLEN-1:0] c_part;
      assign s_part = opnd_gated[0] ^ opnd_gated[1] ^ disp_ext;
      assign c_part = ((opnd_gated[0] & opnd_gated[1]) |
                       (opnd_gated[0] & disp_ext) |
                       (opnd_gated[1] & disp_ext)) << 1;
      assign sum = s_part + c_part;
   end else begin : g_plain
      assign sum = opnd_gated[0] + opnd_gated[1] + disp_ext;
   end

   assign ea = wide_mode ? (sum & WIDE_MASK) : (sum & NARROW_MASK);
endmodule

// File: rtl/amb_link_fmt.sv
module amb_link_fmt
   import amb_pkg::*;
#(
   parameter int XLEN     = 32,
   parameter int NARROW_W = 24
) (
   input  logic            wide_mode,
   input  logic [XLEN-2:0] next_ia,
   input  logic [CC_W-1:0] cc,
   input  logic [PM_W-1:0] prog_mask,
   output logic [XLEN-1:0] link_rr,
   output logic [XLEN-1:0] link_rx,
   output logic [XLEN-1:0] link_save,
   output logic [XLEN-1:0] link_mode
);
   logic [XLEN-1:0] wide_link;
   logic [XLEN-1:0] narrow_plain;
   logic [XLEN-1:0] narrow_rr;
   logic [XLEN-1:0] narrow_rx;

   assign wide_link    = {1'b1, next_ia};
   assign narrow_plain = {{(XLEN-NARROW_W){1'b0}}, next_ia[NARROW_W-1:0]};
   assign narrow_rr    = {ILC_RR, cc, prog_mask, next_ia[NARROW_W-1:0]};
   assign narrow_rx    = {ILC_RX, cc, prog_mask, next_ia[NARROW_W-1:0]};

   assign link_rr   = wide_mode ? wide_link : narrow_rr;
   assign link_rx   = wide_mode ? wide_link : narrow_rx;
   assign link_save = wide_mode ? wide_link : narrow_plain;
   assign link_mode = {wide_mode, next_ia};
endmodule

// File: rtl/amb_mode_reg.sv
module amb_mode_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic load_val,
   output logic mode
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    mode <= 1'b0;
      else if (load) mode <= load_val;
   end
endmodule

// File: rtl/amb_exec_unit.sv
module amb_exec_unit
   import amb_pkg::*;
#(
   parameter int XLEN     = 32,
   parameter int NARROW_W = 24,
   parameter int DISP_W   = 12,
   parameter int RIDX_W   = 4,
   parameter bit ADD3_CSA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              instr_valid,
   input  logic [7:0]        opcode,
   input  logic [RIDX_W-1:0] r2_num,
   input  logic [XLEN-2:0]   r1_low,
   input  logic [XLEN-1:0]   r2_val,
   input  logic [RIDX_W-1:0] base_num,
   input  logic [XLEN-1:0]   base_val,
   input  logic [RIDX_W-1:0] index_num,
   input  logic [XLEN-1:0]   index_val,
   input  logic [DISP_W-1:0] disp,
   input  logic [XLEN-2:0]   next_ia,
   input  logic [CC_W-1:0]   cc,
   input  logic [PM_W-1:0]   prog_mask,
   output logic              wb_en,
   output logic [XLEN-1:0]   wb_data,
   output logic              br_taken,
   output logic [XLEN-1:0]   br_target,
   output logic              amode
);
   localparam int HIGH_W = XLEN - NARROW_W;
   localparam logic [XLEN-1:0] NARROW_MASK = {{HIGH_W{1'b0}}, {NARROW_W{1'b1}}};
   localparam logic [XLEN-1:0] WIDE_MASK   = {1'b0, {(XLEN-1){1'b1}}};

   if (XLEN != 32) begin : g_bad_xlen
      $error("amb_exec_unit: XLEN must be 32");
   end
   if (HIGH_W != ILC_W + CC_W + PM_W) begin : g_bad_narrow
      $error("amb_exec_unit: high byte must hold ilc, cc and mask exactly");
   end
   if (DISP_W >= XLEN || RIDX_W < 1) begin : g_bad_fields
      $error("amb_exec_unit: bad displacement or register index width");
   end

   logic            mode_q;
   logic            mode_ld;
   logic [XLEN-1:0] ea;
   logic [XLEN-1:0] link_rr, link_rx, link_save, link_mode;
   logic [XLEN-1:0] r2_masked;
   logic            r2_live;

   amb_mode_reg u_mode (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (mode_ld),
      .load_val (r2_val[XLEN-1]),
      .mode     (mode_q)
   );

   amb_ea_gen #(
      .XLEN(XLEN), .NARROW_W(NARROW_W), .DISP_W(DISP_W),
      .RIDX_W(RIDX_W), .ADD3_CSA(ADD3_CSA)
   ) u_ea (
      .wide_mode (mode_q),
      .base_num  (base_num),
      .base_val  (base_val),
      .index_num (index_num),
      .index_val (index_val),
      .disp      (disp),
      .ea        (ea)
   );

   amb_link_fmt #(.XLEN(XLEN), .NARROW_W(NARROW_W)) u_link (
      .wide_mode (mode_q),
      .next_ia   (next_ia),
      .cc        (cc),
      .prog_mask (prog_mask),
      .link_rr   (link_rr),
      .link_rx   (link_rx),
      .link_save (link_save),
      .link_mode (link_mode)
   );

   assign r2_live   = (r2_num != '0);
   assign r2_masked = mode_q ? (r2_val & WIDE_MASK) : (r2_val & NARROW_MASK);
   assign amode     = mode_q;

   always_comb begin
      wb_en     = 1'b0;
      wb_data   = '0;
      br_taken  = 1'b0;
      br_target = '0;
      mode_ld   = 1'b0;
      if (instr_valid) begin
         case (opcode)
            OP_MSB, OP_MSBL: begin
               wb_en   = 1'b1;
               wb_data = (opcode == OP_MSB) ? {mode_q, r1_low} : link_mode;
               if (r2_live) begin
                  br_taken  = 1'b1;
                  br_target = r2_val & WIDE_MASK;
                  mode_ld   = 1'b1;
               end
            end
            OP_BALR, OP_BASR: begin
               wb_en   = 1'b1;
               wb_data = (opcode == OP_BALR) ? link_rr : link_save;
               if (r2_live) begin
                  br_taken  = 1'b1;
                  br_target = r2_masked;
               end
            end
            OP_BAL, OP_BAS: begin
               wb_en     = 1'b1;
               wb_data   = (opcode == OP_BAL) ? link_rx : link_save;
               br_taken  = 1'b1;
               br_target = ea;
            end
            OP_LA: begin
               wb_en   = 1'b1;
               wb_data = ea;
            end
            OP_IMASK: begin
               wb_en   = 1'b1;
               wb_data = {2'b00, cc, prog_mask, r1_low[NARROW_W-1:0]};
            end
            default: ;
         endcase
      end
   end

   // R1: reset leaves narrow mode
   a_r1_reset_narrow: assert property (@(posedge clk) !rst_n |=> !amode);

   // R3: mode loaded from the top bit of the second operand
   a_r3_mode_from_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && (opcode == OP_MSB || opcode == OP_MSBL) && r2_num != '0)
      |=> amode == $past(r2_val[XLEN-1]));

   // R4: zero register field keeps mode and does not branch
   a_r4_zero_field_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && (opcode == OP_MSB || opcode == OP_MSBL) && r2_num == '0)
      |-> !br_taken ##1 $stable(amode));

   // R8: no other instruction moves the mode
   a_r8_mode_only_by_msb: assert property (@(posedge clk) disable iff (!rst_n)
      !(instr_valid && (opcode == OP_MSB || opcode == OP_MSBL)) |=> $stable(amode));

   // R6: load address clears bit 31 in wide mode, the high byte in narrow mode
   a_r6_la_wide_top: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && opcode == OP_LA && amode) |-> !wb_data[XLEN-1]);
   a_r6_la_narrow_high: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && opcode == OP_LA && !amode) |-> wb_data[XLEN-1:NARROW_W] == '0);

   // R12: idle cycles are quiet
   a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !instr_valid |-> (!wb_en && !br_taken && br_target == '0));
endmodule

// File: tb/amb_exec_unit_tb.sv
`timescale 1ns/1ps
module amb_exec_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        instr_valid = 1'b0;
   logic [7:0]  opcode = 8'h00;
   logic [3:0]  r2_num = 4'd0;
   logic [30:0] r1_low = '0;
   logic [31:0] r2_val = '0;
   logic [3:0]  base_num = 4'd0;
   logic [31:0] base_val = '0;
   logic [3:0]  index_num = 4'd0;
   logic [31:0] index_val = '0;
   logic [11:0] disp = '0;
   logic [30:0] next_ia = '0;
   logic [1:0]  cc = '0;
   logic [3:0]  prog_mask = '0;
   logic        wb_en;
   logic [31:0] wb_data;
   logic        br_taken;
   logic [31:0] br_target;
   logic        amode;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;
   logic [31:0] seed = 32'h1357_9BDF;
   logic exp_mode = 1'b0;

   always #2.5 clk = ~clk;

   amb_exec_unit u_dut (
      .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .opcode(opcode),
      .r2_num(r2_num), .r1_low(r1_low), .r2_val(r2_val),
      .base_num(base_num), .base_val(base_val), .index_num(index_num),
      .index_val(index_val), .disp(disp), .next_ia(next_ia), .cc(cc),
      .prog_mask(prog_mask), .wb_en(wb_en), .wb_data(wb_data),
      .br_taken(br_taken), .br_target(br_target), .amode(amode)
   );

   function automatic logic [31:0] rnd(input logic [31:0] s);
      logic [31:0] x = s;
      x = x ^ (x << 13);
      x = x ^ (x >> 17);
      x = x ^ (x << 5);
      return x;
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s op=%h mode=%0d actual=%h expected=%h",
                  req, what, opcode, exp_mode, act, exp);
      end
   endtask

   function automatic string req_of(input logic [7:0] op);
      case (op)
         8'h0B: return "R2";
         8'h0C: return "R5";
         8'h05, 8'h45: return "R9";
         8'h0D, 8'h4D: return "R10";
         8'h41: return "R6";
         8'hB2: return "R7";
         default: return "R12";
      endcase
   endfunction

   // Drive one instruction, check the same-cycle outputs and the mode after the edge
   task automatic issue(input logic [7:0] op, input logic m);
      logic [31:0] ea_raw, ea, r2m, save_l, wb_e, tg_e;
      logic        en_e, br_e, nz;
      @(negedge clk);
      opcode = op;
      instr_valid = 1'b1;
      nz = (r2_num != 4'd0);
      ea_raw = ((base_num != 0) ? base_val : 32'd0) + ((index_num != 0) ? index_val : 32'd0)
               + {20'd0, disp};
      ea     = m ? (ea_raw & 32'h7FFF_FFFF) : (ea_raw & 32'h00FF_FFFF);
      r2m    = m ? (r2_val & 32'h7FFF_FFFF) : (r2_val & 32'h00FF_FFFF);
      save_l = m ? {1'b1, next_ia} : {8'h00, next_ia[23:0]};
      en_e = 1'b1; wb_e = '0; br_e = 1'b0; tg_e = '0;
      case (op)
         8'h0B: begin wb_e = {m, r1_low}; br_e = nz; tg_e = nz ? {1'b0, r2_val[30:0]} : 0; end
         8'h0C: begin wb_e = {m, next_ia}; br_e = nz; tg_e = nz ? {1'b0, r2_val[30:0]} : 0; end
         8'h05: begin wb_e = m ? {1'b1, next_ia} : {2'b01, cc, prog_mask, next_ia[23:0]};
                      br_e = nz; tg_e = nz ? r2m : 0; end
         8'h0D: begin wb_e = save_l; br_e = nz; tg_e = nz ? r2m : 0; end
         8'h45: begin wb_e = m ? {1'b1, next_ia} : {2'b10, cc, prog_mask, next_ia[23:0]};
                      br_e = 1'b1; tg_e = ea; end
         8'h4D: begin wb_e = save_l; br_e = 1'b1; tg_e = ea; end
         8'h41: wb_e = ea;
         8'hB2: wb_e = {2'b00, cc, prog_mask, r1_low[23:0]};
         default: en_e = 1'b0;
      endcase
      #1;
      chk(req_of(op), "wb_en", {31'd0, wb_en}, {31'd0, en_e});
      chk(req_of(op), "wb_data", wb_data, wb_e);
      chk((op == 8'h0B || op == 8'h0C) ? (nz ? "R3" : "R4") : "R11",
          "br_taken", {31'd0, br_taken}, {31'd0, br_e});
      chk((op == 8'h0B || op == 8'h0C) ? (nz ? "R3" : "R4") : "R11",
          "br_target", br_target, tg_e);
      if ((op == 8'h0B || op == 8'h0C) && nz) exp_mode = r2_val[31];
      @(posedge clk);
      #1 instr_valid = 1'b0;
      @(negedge clk);
      chk((op == 8'h0B || op == 8'h0C) ? (nz ? "R3" : "R4") : "R8",
          "amode", {31'd0, amode}, {31'd0, exp_mode});
   endtask

   task automatic set_mode(input logic m);
      r2_num = 4'd7;
      r2_val = {m, 31'h0000_1000};
      issue(8'h0B, exp_mode);
   endtask

   initial begin
      logic [7:0] ops [9];
      ops = '{8'h0B, 8'h0C, 8'h05, 8'h0D, 8'h45, 8'h4D, 8'h41, 8'hB2, 8'h00};
      repeat (3) @(posedge clk);
      #1;
      chk("R1", "amode in reset", {31'd0, amode}, 32'd0);
      chk("R12", "wb_en in reset", {31'd0, wb_en}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "amode after reset", {31'd0, amode}, 32'd0);

      // idle with a mode-branch opcode present: no effect (R12, R8)
      opcode = 8'h0B; r2_num = 4'd3; r2_val = 32'hFFFF_FFFF;
      @(negedge clk);
      chk("R12", "idle wb_en", {31'd0, wb_en}, 32'd0);
      chk("R12", "idle br_taken", {31'd0, br_taken}, 32'd0);
      chk("R8", "idle amode", {31'd0, amode}, 32'd0);

      for (int m = 0; m < 2; m++) begin
         for (int k = 0; k < 9; k++) begin
            for (int z = 0; z < 2; z++) begin
               for (int rep = 0; rep < 4; rep++) begin
                  if (exp_mode != m[0]) set_mode(m[0]);
                  seed = rnd(seed); r1_low    = seed[30:0];
                  seed = rnd(seed); r2_val    = {rep[0], seed[30:0]};
                  seed = rnd(seed); base_val  = seed;
                  seed = rnd(seed); index_val = seed;
                  seed = rnd(seed); disp      = seed[11:0];
                  cc = seed[13:12]; prog_mask = seed[17:14];
                  seed = rnd(seed); next_ia   = seed[30:0];
                  r2_num    = (z == 1) ? 4'd0 : 4'(rep + 1);
                  base_num  = rep[0] ? 4'd0 : 4'd3;
                  index_num = rep[1] ? 4'd0 : 4'd5;
                  issue(ops[k], m[0]);
               end
            end
         end
      end

      // register number equal for both operands: second operand value drives the branch (R11)
      set_mode(1'b1);
      r2_num = 4'd6; r2_val = 32'hFEDC_BA98; next_ia = 31'h0123_4567;
      issue(8'h0D, 1'b1);

      // wraparound of the address sum in both modes (R6)
      base_num = 4'd1; index_num = 4'd2; base_val = 32'hFFFF_FFFF; index_val = 32'h8000_0001;
      disp = 12'hFFF;
      issue(8'h41, 1'b1);
      set_mode(1'b0);
      issue(8'h41, 1'b0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule